// File: doc/BRIEF.md
# Serial-Loaded Program Bank Switcher

This block sits on the cartridge side of a CPU bus and maps two 16 KB program windows onto physical banks. The CPU cannot write a full register value in one write. It sends one bit per write to any address with bit 15 set, always in data bit 0. Five such writes build a 5-bit value, least significant bit first. On the fifth write, address bits 14:13 choose which internal register takes the value. Select 0 is the control register and select 3 is the program-bank register. Selects 1 and 2 belong to registers outside this block, so the value is dropped.

The control register holds a program-bank mode in bits 3:2 and a name-table mirroring code in bits 1:0. A write with data bit 7 set abandons any partial sequence and forces the last-bank-fixed mode. The bank indices for the lower and upper windows are registered outputs. They change on the clock edge of a committing write or a reset write.

Top module: `serial_bank_switch`

## Requirements
- R1: After reset, the lower window shows bank 0, the upper window shows bank LAST_BANK, and the mirroring code is 0. The control register resets to mode 3 and mirror 0.
- R2: A write counts when wr_en is high and addr[15] is 1. Each such write shifts data bit 0 in. On the fifth counted write, the bits form the value bit0..bit4 in write order, and that value is committed.
- R3: The first four counted writes of a sequence do not change any output.
- R4: A counted write with data bit 7 set clears the shift sequence, whatever the write count. It sets control bits 3:2 to 3 and leaves control bits 1:0 and the bank register unchanged. This takes precedence over a fifth-write commit in the same cycle.
- R5: On the committing write, addr[14:13] picks the target. 0 loads the control register and 3 loads the bank register. 1 and 2 load neither register, but the sequence still restarts.
- R6: In modes 0 and 1, the lower window shows the bank value with bit 0 cleared, and the upper window shows it with bit 0 set. Bits 3:1 of the bank register are used.
- R7: In mode 2, the lower window is fixed at bank 0, and the upper window shows bank-register bits 2:0.
- R8: In mode 3, the lower window shows bank-register bits 2:0, and the upper window is fixed at LAST_BANK. Bank-register bit 3 is ignored in modes 2 and 3.
- R9: mirror_mode outputs control bits 1:0. The codes are 0 single-screen low, 1 single-screen high, 2 vertical and 3 horizontal.
- R10: Writes with addr[15] at 0, or with wr_en low, have no effect on the sequence or on any output. This includes writes with data bit 7 set.
- R11: Outputs change only on the clock edge of a committing or reset write. They are sampled as the new values in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle CPU write strobe |
| addr | input | 16 | CPU write address |
| wdata | input | 8 | CPU write data |
| prg_lo_bank | output | BANK_W | Physical bank for the lower 16 KB window |
| prg_hi_bank | output | BANK_W | Physical bank for the upper 16 KB window |
| mirror_mode | output | 2 | Name-table mirroring code |

## Verification
Two functions can fall in the same cycle: the commit of an assembled value and the reset request carried by data bit 7. The bench provokes this by shifting four bits toward the bank register and then sending a fifth write with both bit 7 and bit 0 set. It judges the result by two things. First, the bank outputs must be unchanged, with only the mode forced. Second, a following clean five-write sequence must commit correctly, which shows the write counter was cleared and not left at four.

// File: rtl/serial_bank_switch.sv
module serial_bank_switch #(
  parameter int BANK_W = 4,
  parameter logic [BANK_W-1:0] LAST_BANK = {BANK_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       addr,
  input  logic [7:0]        wdata,
  output logic [BANK_W-1:0] prg_lo_bank,
  output logic [BANK_W-1:0] prg_hi_bank,
  output logic [1:0]        mirror_mode
);
  localparam logic [4:0] CTRL_RST = 5'b01100;

  logic [4:0] shf_q, shf_d, ctrl_q, ctrl_d, prg_q, prg_d;
  logic [2:0] cnt_q, cnt_d;
  logic [BANK_W-1:0] lo_d, hi_d;

  wire hit = wr_en & addr[15];
  wire [4:0] joined = {wdata[0], shf_q[4:1]};
  wire [BANK_W-1:0] sub_bank = BANK_W'(prg_d[2:0]);
  wire unused_bits = &{1'b0, addr[12:0], wdata[6:1]};

  always_comb begin
    shf_d  = shf_q;
    cnt_d  = cnt_q;
    ctrl_d = ctrl_q;
    prg_d  = prg_q;
    if (hit) begin
      if (wdata[7]) begin
        shf_d = '0;
        cnt_d = '0;
        ctrl_d[3:2] = 2'b11;
      end else if (cnt_q == 3'd4) begin
        shf_d = '0;
        cnt_d = '0;
        case (addr[14:13])
          2'd0:    ctrl_d = joined;
          2'd3:    prg_d  = joined;
          default: ;
        endcase
      end else begin
        shf_d = joined;
        cnt_d = cnt_q + 3'd1;
      end
    end
  end

  always_comb begin
    case (ctrl_d[3:2])
      2'd2: begin
        lo_d = '0;
        hi_d = sub_bank;
      end
      2'd3: begin
        lo_d = sub_bank;
        hi_d = LAST_BANK;
      end
      default: begin
        lo_d = {prg_d[BANK_W-1:1], 1'b0};
        hi_d = {prg_d[BANK_W-1:1], 1'b1};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shf_q       <= '0;
      cnt_q       <= '0;
      ctrl_q      <= CTRL_RST;
      prg_q       <= '0;
      prg_lo_bank <= '0;
      prg_hi_bank <= LAST_BANK;
    end else begin
      shf_q       <= shf_d;
      cnt_q       <= cnt_d;
      ctrl_q      <= ctrl_d;
      prg_q       <= prg_d;
      prg_lo_bank <= lo_d;
      prg_hi_bank <= hi_d;
    end
  end

  assign mirror_mode = ctrl_q[1:0];

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 3'd4);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(prg_lo_bank) && $stable(prg_hi_bank) && $stable(mirror_mode)));

  // R3
  partial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !wdata[7] && cnt_q != 3'd4)
      |=> ($stable(prg_lo_bank) && $stable(prg_hi_bank) && $stable(mirror_mode)));

  // R4
  reset_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wdata[7]) |=> (prg_hi_bank == LAST_BANK && $stable(mirror_mode) && cnt_q == 3'd0));

  // R6
  pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[3] |-> (!prg_lo_bank[0] && prg_hi_bank == {prg_lo_bank[BANK_W-1:1], 1'b1}));

  // R7
  fixed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[3:2] == 2'b10) |-> (prg_lo_bank == '0));

  // R8
  fixed_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[3:2] == 2'b11) |-> (prg_hi_bank == LAST_BANK));
endmodule

// File: tb/sim_serial_bank_switch.sv
module sim_serial_bank_switch;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] lo, hi;
  logic [1:0] mir;
  int runs = 0;
  int fails = 0;
  bit done = 1'b0;

  // {addr[15:0], value[4:0], lo[3:0], hi[3:0], mirror[1:0]}
  localparam logic [30:0] VEC [NV] = '{
    {16'hE000, 5'h05, 4'd5,  4'd15, 2'd0},
    {16'hE000, 5'h0D, 4'd5,  4'd15, 2'd0},
    {16'h8000, 5'h0B, 4'd0,  4'd5,  2'd3},
    {16'hE000, 5'h0A, 4'd0,  4'd2,  2'd3},
    {16'h8000, 5'h02, 4'd10, 4'd11, 2'd2},
    {16'h8000, 5'h05, 4'd10, 4'd11, 2'd1},
    {16'hE000, 5'h07, 4'd6,  4'd7,  2'd1},
    {16'hA000, 5'h1F, 4'd6,  4'd7,  2'd1},
    {16'hC000, 5'h00, 4'd6,  4'd7,  2'd1},
    {16'h9FFF, 5'h0C, 4'd7,  4'd15, 2'd0},
    {16'hFFFF, 5'h12, 4'd2,  4'd15, 2'd0}
  };

  serial_bank_switch u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .prg_lo_bank(lo), .prg_hi_bank(hi), .mirror_mode(mir)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [3:0] elo, input logic [3:0] ehi,
                     input logic [1:0] emir);
    runs++;
    if (lo !== elo || hi !== ehi || mir !== emir) begin
      fails++;
      $display("FAIL %s: got lo=%0d hi=%0d mir=%0d, expected lo=%0d hi=%0d mir=%0d",
               tag, lo, hi, mir, elo, ehi, emir);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en = 1'b1);
    @(negedge clk);
    wr_en = en; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] a, input logic [4:0] v);
    for (int i = 0; i < 5; i++) wr(a, {7'd0, v[i]});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    runs++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", 4'd0, 4'd15, 2'd0);

    // R2 R5 R6 R7 R8 R9 table walk
    for (int k = 0; k < NV; k++) begin
      load(VEC[k][30:15], VEC[k][14:10]);
      chk($sformatf("R2/R5/R6/R7/R8/R9 vector %0d", k), VEC[k][9:6], VEC[k][5:2], VEC[k][1:0]);
    end

    // R3: four shifts leave outputs alone
    for (int i = 0; i < 4; i++) wr(16'hE000, {7'd0, 1'b1});
    chk("R3 partial sequence", 4'd2, 4'd15, 2'd0);

    // R4: reset bit on the would-be fifth write wins over commit
    wr(16'hE000, 8'h81);
    chk("R4 reset beats commit", 4'd2, 4'd15, 2'd0);

    // R4: counter was cleared, a fresh sequence commits cleanly
    load(16'h8000, 5'h0B);
    chk("R4 counter cleared", 4'd0, 4'd2, 2'd3);

    // R4: reset write at count zero forces mode 3, keeps mirror
    wr(16'h8000, 8'h80);
    chk("R4 mode forced", 4'd2, 4'd15, 2'd3);

    // R10: ignored writes interleaved in a sequence
    wr(16'h8000, 8'h00);
    wr(16'h8000, 8'h01);
    wr(16'h7FFF, 8'h01);
    wr(16'h7FFF, 8'h80);
    wr(16'h8000, 8'h80, 1'b0);
    wr(16'h8000, 8'h00);
    wr(16'h8000, 8'h01);
    wr(16'h8000, 8'h00);
    chk("R10 ignored writes", 4'd0, 4'd2, 2'd2);

    // R11: outputs move only after the committing edge
    for (int i = 0; i < 4; i++) wr(16'hE000, {7'd0, (i == 2)});
    @(negedge clk);
    wr_en = 1'b1; addr = 16'hE000; wdata = 8'h00;
    #1;
    chk("R11 before commit edge", 4'd0, 4'd2, 2'd2);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11 after commit edge", 4'd0, 4'd4, 2'd2);

    finish_run();
  end
endmodule